// File: doc/BRIEF.md
# Packet Buffer Ownership Switch

This block keeps the ownership record for a pool of eight 512-byte packet buffers that a packet engine and a parallel I/O port share. Each buffer belongs to exactly one side at a time. When a side has finished with a buffer, it commits that buffer to the other side. The switch then rewrites one owner bit and one pointer. No data moves. The storage array stays outside the block, and this switch never reads or writes it. The switch only tells each side which buffer index it must use next.

The pool is split into two endpoints, and each endpoint has four buffer slots. Buffer index = endpoint × 4 + slot. A configuration field sets how many of an endpoint's slots are in use, from one to four. This gives single, double, triple or quad buffering. Either side may commit, so the same mechanism carries data in both directions. The packet side fills buffers and hands them to the I/O side, which drains them and hands them back, or the reverse. Every commit also carries a byte count. The receiving side sees that count together with the buffer index it is about to take over.

Top module: `buf_owner_switch`

## Requirements
- R1: Out of reset, the packet side owns all eight buffers, so `own_io` is 0. Bit b of `own_io` is 1 exactly when the I/O side owns buffer b, where b = endpoint × 4 + slot.
- R2: Field `cfg_depth[2e+1:2e]` with value v gives endpoint e a depth of v+1 buffers, using slots 0..v. The field is captured only while `rst_n` is low. A change after reset has no effect, and slots beyond the depth always stay with the packet side.
- R3: Each side commits its own head buffer. Its head pointer then advances round-robin through slots 0..depth-1, so buffers return in the order they were handed over. `pk_buf` and `io_buf` show the index of each side's head buffer.
- R4: A commit carries a byte count from 0 to 512, stored for that buffer. From the next cycle, the receiving side's `*_len` output shows the stored count of its head buffer. Stored counts reset to 0.
- R5: `io_empty[e]` is high exactly when the I/O side owns no buffer of endpoint e. `pk_full[e]` is high exactly when the I/O side owns all depth buffers of endpoint e.
- R6: A commit from a side that owns no buffer of that endpoint changes no ownership and sets the sticky error bit `err[e]`. That bit stays high until reset.
- R7: A commit whose byte count is above 512 is ignored and sets `err[e]`.
- R8: A legal commit changes ownership at the next clock edge. Both sides may commit on the same endpoint in the same cycle. Each commit is judged against the state before that edge.
- R9: Commits, errors and configuration on one endpoint never change another endpoint's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; depth configuration is captured while low |
| cfg_depth | input | 4 | Per-endpoint depth minus one, 2 bits per endpoint |
| pk_commit | input | 2 | Packet side hands its head buffer of endpoint e to the I/O side |
| pk_count | input | 20 | Byte count per endpoint for packet commits, 10 bits each |
| io_commit | input | 2 | I/O side hands its head buffer of endpoint e to the packet side |
| io_count | input | 20 | Byte count per endpoint for I/O commits, 10 bits each |
| pk_buf | output | 6 | Packet-side head buffer index per endpoint, 3 bits each |
| pk_len | output | 20 | Stored byte count of the packet-side head buffer, 10 bits each |
| io_buf | output | 6 | I/O-side head buffer index per endpoint, 3 bits each |
| io_len | output | 20 | Stored byte count of the I/O-side head buffer, 10 bits each |
| own_io | output | 8 | Per-buffer owner: 1 = I/O side, 0 = packet side |
| pk_full | output | 2 | All buffers of the endpoint are with the I/O side |
| io_empty | output | 2 | The I/O side owns no buffer of the endpoint |
| err | output | 2 | Sticky per-endpoint illegal-commit flag |

## Verification
Several properties are checked on every cycle. The owner bitmap always agrees with each endpoint's occupancy count, head pointers stay inside the configured depth, and unused slots never leave the packet side. The captured depth holds still, full and empty are never high together, stored counts never exceed 512, both write ports never hit the same slot, and an error flag never falls. Other behaviour shows only in the bench's scenarios. These cover the round-robin order and wrap of the indices, the byte count delivered to the receiving side, rejection of illegal and oversize commits, a same-cycle commit from both sides, a configuration change after reset, and the isolation between endpoints.

// File: rtl/bos_pkg.sv
// Shared definitions for the buffer ownership switch.
// Assumes: the owner of a buffer is one of exactly two sides.
package bos_pkg;
    typedef enum logic {
        OWN_PKT = 1'b0,
        OWN_IO  = 1'b1
    } owner_e;
endpackage

// File: rtl/bos_len_bank.sv
// Byte-count store for the slots of one endpoint.
// Each slot keeps the count written with its last commit. Two write ports
// (packet commit, I/O commit) and two read ports (each side's head slot).
// Assumes: the controller never enables both writes on the same slot.
module bos_len_bank #(
    parameter int MAX_DEPTH = 4,
    parameter int BYTES     = 512,
    localparam int SLOT_W   = $clog2(MAX_DEPTH),
    localparam int CNT_W    = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pk_we,
    input  logic [SLOT_W-1:0] pk_slot,
    input  logic [CNT_W-1:0]  pk_wdata,
    input  logic              io_we,
    input  logic [SLOT_W-1:0] io_slot,
    input  logic [CNT_W-1:0]  io_wdata,
    output logic [CNT_W-1:0]  pk_rdata,
    output logic [CNT_W-1:0]  io_rdata
);
    localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(BYTES);

    logic [CNT_W-1:0] len_q [MAX_DEPTH];

    // Store the count of each committed buffer; clear all counts on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < MAX_DEPTH; s++) len_q[s] <= '0;
        end else begin
            if (pk_we) len_q[pk_slot] <= pk_wdata;
            if (io_we) len_q[io_slot] <= io_wdata;
        end
    end

    // Present the count of the buffer each side will handle next.
    always_comb begin
        pk_rdata = len_q[pk_slot];
        io_rdata = len_q[io_slot];
    end

    AST_WR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_we && io_we) |-> (pk_slot != io_slot)); // R8

    for (genvar s = 0; s < MAX_DEPTH; s++) begin : g_chk
        AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            len_q[s] <= MAX_LEN); // R4
    end
endmodule

// File: rtl/bos_ep_ctrl.sv
// Ownership controller for one endpoint.
// Keeps two round-robin head pointers, a count of buffers held by the I/O
// side, and one owner bit per slot. Judges each commit against the state
// before the edge, and flags illegal commits in a sticky error bit.
// Assumes: the depth field is steady while reset is low.
module bos_ep_ctrl
    import bos_pkg::*;
#(
    parameter int MAX_DEPTH = 4,
    parameter int BYTES     = 512,
    localparam int SLOT_W   = $clog2(MAX_DEPTH),
    localparam int OCC_W    = $clog2(MAX_DEPTH + 1),
    localparam int CNT_W    = $clog2(BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_W-1:0]    cfg_depth_m1,
    input  logic                 pk_commit,
    input  logic [CNT_W-1:0]     pk_count,
    input  logic                 io_commit,
    input  logic [CNT_W-1:0]     io_count,
    output logic [SLOT_W-1:0]    pk_slot,
    output logic [SLOT_W-1:0]    io_slot,
    output logic [MAX_DEPTH-1:0] own_bits,
    output logic                 pk_full,
    output logic                 io_empty,
    output logic                 err,
    output logic                 pk_we,
    output logic                 io_we
);
    localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(BYTES);

    logic [SLOT_W-1:0] depth_m1_q;
    logic [SLOT_W-1:0] pk_ptr_q, io_ptr_q, pk_nxt, io_nxt;
    logic [OCC_W-1:0]  io_cnt_q, depth_w;
    owner_e            own_q [MAX_DEPTH];
    logic              err_q, pk_ok, io_ok, bad;

    // Judge both commits against the current state and derive next pointers.
    always_comb begin
        depth_w = OCC_W'(depth_m1_q) + OCC_W'(1);
        pk_ok   = pk_commit && (io_cnt_q != depth_w) && (pk_count <= MAX_LEN);
        io_ok   = io_commit && (io_cnt_q != '0) && (io_count <= MAX_LEN);
        bad     = (pk_commit && !pk_ok) || (io_commit && !io_ok);
        pk_nxt  = (pk_ptr_q == depth_m1_q) ? '0 : pk_ptr_q + SLOT_W'(1);
        io_nxt  = (io_ptr_q == depth_m1_q) ? '0 : io_ptr_q + SLOT_W'(1);
    end

    // Update pointers, occupancy, owner bits and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_m1_q <= cfg_depth_m1;
            pk_ptr_q   <= '0;
            io_ptr_q   <= '0;
            io_cnt_q   <= '0;
            err_q      <= 1'b0;
            for (int s = 0; s < MAX_DEPTH; s++) own_q[s] <= OWN_PKT;
        end else begin
            if (pk_ok) begin
                pk_ptr_q        <= pk_nxt;
                own_q[pk_ptr_q] <= OWN_IO;
            end
            if (io_ok) begin
                io_ptr_q        <= io_nxt;
                own_q[io_ptr_q] <= OWN_PKT;
            end
            case ({pk_ok, io_ok})
                2'b10:   io_cnt_q <= io_cnt_q + OCC_W'(1);
                2'b01:   io_cnt_q <= io_cnt_q - OCC_W'(1);
                default: io_cnt_q <= io_cnt_q;
            endcase
            err_q <= err_q | bad;
        end
    end

    // Drive status and the write enables for the count store.
    always_comb begin
        for (int s = 0; s < MAX_DEPTH; s++) own_bits[s] = (own_q[s] == OWN_IO);
        pk_slot  = pk_ptr_q;
        io_slot  = io_ptr_q;
        pk_full  = (io_cnt_q == depth_w);
        io_empty = (io_cnt_q == '0);
        err      = err_q;
        pk_we    = pk_ok;
        io_we    = io_ok;
    end

    AST_OWN_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(own_bits) == int'(io_cnt_q)); // R1
    AST_DEPTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(depth_m1_q)); // R2
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_ptr_q <= depth_m1_q) && (io_ptr_q <= depth_m1_q)); // R3
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pk_full && io_empty)); // R5
    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_commit && pk_full && !io_commit) |=> $stable(io_cnt_q)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R6

    for (genvar s = 0; s < MAX_DEPTH; s++) begin : g_idle
        AST_IDLE_SLOT_PKT: assert property (@(posedge clk) disable iff (!rst_n)
            (SLOT_W'(s) > depth_m1_q) |-> (own_q[s] == OWN_PKT)); // R2
    end
endmodule

// File: rtl/buf_owner_switch.sv
// Top of the buffer ownership switch.
// Splits the buffer pool into endpoints of MAX_DEPTH slots each. Buffer
// index = endpoint * MAX_DEPTH + slot. Instantiates one controller and one
// count store per endpoint and packs their outputs into flat vectors.
// Assumes: NUM_BUF is a multiple of MAX_DEPTH and MAX_DEPTH is a power of two.
module buf_owner_switch #(
    parameter int NUM_BUF   = 8,
    parameter int MAX_DEPTH = 4,
    parameter int BYTES     = 512,
    localparam int NUM_EP   = NUM_BUF / MAX_DEPTH,
    localparam int SLOT_W   = $clog2(MAX_DEPTH),
    localparam int BIDX_W   = $clog2(NUM_BUF),
    localparam int CNT_W    = $clog2(BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EP*SLOT_W-1:0]   cfg_depth,
    input  logic [NUM_EP-1:0]          pk_commit,
    input  logic [NUM_EP*CNT_W-1:0]    pk_count,
    input  logic [NUM_EP-1:0]          io_commit,
    input  logic [NUM_EP*CNT_W-1:0]    io_count,
    output logic [NUM_EP*BIDX_W-1:0]   pk_buf,
    output logic [NUM_EP*CNT_W-1:0]    pk_len,
    output logic [NUM_EP*BIDX_W-1:0]   io_buf,
    output logic [NUM_EP*CNT_W-1:0]    io_len,
    output logic [NUM_BUF-1:0]         own_io,
    output logic [NUM_EP-1:0]          pk_full,
    output logic [NUM_EP-1:0]          io_empty,
    output logic [NUM_EP-1:0]          err
);
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic [SLOT_W-1:0] pk_slot, io_slot;
        logic              pk_we, io_we;

        bos_ep_ctrl #(.MAX_DEPTH(MAX_DEPTH), .BYTES(BYTES)) u_ctrl (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_depth_m1 (cfg_depth[e*SLOT_W +: SLOT_W]),
            .pk_commit    (pk_commit[e]),
            .pk_count     (pk_count[e*CNT_W +: CNT_W]),
            .io_commit    (io_commit[e]),
            .io_count     (io_count[e*CNT_W +: CNT_W]),
            .pk_slot      (pk_slot),
            .io_slot      (io_slot),
            .own_bits     (own_io[e*MAX_DEPTH +: MAX_DEPTH]),
            .pk_full      (pk_full[e]),
            .io_empty     (io_empty[e]),
            .err          (err[e]),
            .pk_we        (pk_we),
            .io_we        (io_we)
        );

        bos_len_bank #(.MAX_DEPTH(MAX_DEPTH), .BYTES(BYTES)) u_len (
            .clk      (clk),
            .rst_n    (rst_n),
            .pk_we    (pk_we),
            .pk_slot  (pk_slot),
            .pk_wdata (pk_count[e*CNT_W +: CNT_W]),
            .io_we    (io_we),
            .io_slot  (io_slot),
            .io_wdata (io_count[e*CNT_W +: CNT_W]),
            .pk_rdata (pk_len[e*CNT_W +: CNT_W]),
            .io_rdata (io_len[e*CNT_W +: CNT_W])
        );

        // Map each endpoint's head slots to global buffer indices.
        assign pk_buf[e*BIDX_W +: BIDX_W] = BIDX_W'(e * MAX_DEPTH) + BIDX_W'(pk_slot);
        assign io_buf[e*BIDX_W +: BIDX_W] = BIDX_W'(e * MAX_DEPTH) + BIDX_W'(io_slot);
    end
endmodule

// File: tb/tb_buf_owner_switch.sv
module tb_buf_owner_switch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_depth = 4'b0011;
    logic [1:0]  pk_commit = '0, io_commit = '0;
    logic [19:0] pk_count = '0, io_count = '0;
    logic [5:0]  pk_buf, io_buf;
    logic [19:0] pk_len, io_len;
    logic [7:0]  own_io;
    logic [1:0]  pk_full, io_empty, err;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    buf_owner_switch dut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .pk_commit(pk_commit), .pk_count(pk_count),
        .io_commit(io_commit), .io_count(io_count),
        .pk_buf(pk_buf), .pk_len(pk_len), .io_buf(io_buf), .io_len(io_len),
        .own_io(own_io), .pk_full(pk_full), .io_empty(io_empty), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] cfg);
        rst_n = 1'b0;
        cfg_depth = cfg;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One commit cycle; returns at the next falling edge with inputs cleared.
    task automatic pulse(input logic [1:0] pkm, input int pc0, input int pc1,
                         input logic [1:0] iom, input int ic0, input int ic1);
        pk_commit = pkm; pk_count = {10'(pc1), 10'(pc0)};
        io_commit = iom; io_count = {10'(ic1), 10'(ic0)};
        @(posedge clk);
        @(negedge clk);
        pk_commit = '0; io_commit = '0;
    endtask

    task automatic t_reset;
        do_reset(4'b0011);
        chk("R1 own_io after reset", own_io, 0);
        chk("R5 io_empty after reset", io_empty, 3);
        chk("R5 pk_full after reset", pk_full, 0);
        chk("R6 err after reset", err, 0);
        chk("R3 pk_buf ep1 base", pk_buf[5:3], 4);
        chk("R3 io_buf ep0 base", io_buf[2:0], 0);
    endtask

    task automatic t_fill_drain;
        do_reset(4'b0011);
        pulse(2'b01, 10, 0, 2'b00, 0, 0);
        chk("R1 first handover own", own_io, 8'h01);
        chk("R4 io_len after commit", io_len[9:0], 10);
        chk("R3 pk head advances", pk_buf[2:0], 1);
        chk("R5 io_empty clears", io_empty[0], 0);
        pulse(2'b01, 20, 0, 2'b00, 0, 0);
        pulse(2'b01, 30, 0, 2'b00, 0, 0);
        pulse(2'b01, 40, 0, 2'b00, 0, 0);
        chk("R5 full at depth 4", pk_full[0], 1);
        chk("R1 all four with io", own_io, 8'h0F);
        chk("R3 pk head wraps", pk_buf[2:0], 0);
        pulse(2'b01, 50, 0, 2'b00, 0, 0);
        chk("R6 commit when full sets err", err, 1);
        chk("R6 commit when full ignored", own_io, 8'h0F);
        pulse(2'b00, 0, 0, 2'b01, 100, 0);
        chk("R3 oldest buffer returns first", own_io, 8'h0E);
        chk("R4 pk_len on takeover", pk_len[9:0], 100);
        chk("R4 io_len next head", io_len[9:0], 20);
        chk("R3 io head advances", io_buf[2:0], 1);
        pulse(2'b00, 0, 0, 2'b01, 101, 0);
        pulse(2'b00, 0, 0, 2'b01, 102, 0);
        pulse(2'b00, 0, 0, 2'b01, 103, 0);
        chk("R5 empty after drain", io_empty[0], 1);
        chk("R3 io head wraps", io_buf[2:0], 0);
        pulse(2'b00, 0, 0, 2'b01, 7, 0);
        chk("R6 io commit when empty ignored", own_io, 0);
        chk("R6 err stays set", err, 1);
    endtask

    task automatic t_depth1_isolation;
        do_reset(4'b0011);
        pulse(2'b10, 0, 512, 2'b00, 0, 0);
        chk("R5 depth1 full", pk_full[1], 1);
        chk("R4 512 bytes accepted", io_len[19:10], 512);
        chk("R2 depth1 pk head stays", pk_buf[5:3], 4);
        chk("R9 ep0 untouched", own_io[3:0], 0);
        chk("R1 buffer 4 to io", own_io, 8'h10);
        pulse(2'b10, 0, 1, 2'b00, 0, 0);
        chk("R9 err only on ep1", err, 2);
        chk("R6 ep1 unchanged", own_io, 8'h10);
        pulse(2'b00, 0, 0, 2'b10, 0, 3);
        chk("R4 pk_len ep1", pk_len[19:10], 3);
        chk("R5 ep1 empty again", io_empty[1], 1);
    endtask

    task automatic t_cfg_after_reset;
        do_reset(4'b0011);
        cfg_depth = 4'b0001;
        pulse(2'b01, 1, 0, 2'b00, 0, 0);
        pulse(2'b01, 2, 0, 2'b00, 0, 0);
        pulse(2'b01, 3, 0, 2'b00, 0, 0);
        chk("R2 late cfg ignored, not full", pk_full[0], 0);
        chk("R2 third slot used", own_io, 8'h07);
        pulse(2'b01, 4, 0, 2'b00, 0, 0);
        chk("R2 full at captured depth", pk_full[0], 1);
    endtask

    task automatic t_oversize;
        do_reset(4'b0011);
        pulse(2'b01, 513, 0, 2'b00, 0, 0);
        chk("R7 oversize ignored", own_io, 0);
        chk("R7 oversize sets err", err, 1);
        do_reset(4'b0011);
        pulse(2'b01, 0, 0, 2'b00, 0, 0);
        chk("R4 zero count accepted", own_io, 8'h01);
        chk("R4 zero len shown", io_len[9:0], 0);
        chk("R7 no err on zero", err, 0);
        pulse(2'b00, 0, 0, 2'b01, 600, 0);
        chk("R7 io oversize ignored", own_io, 8'h01);
        chk("R7 io oversize err", err, 1);
    endtask

    task automatic t_simultaneous;
        do_reset(4'b0011);
        pulse(2'b01, 5, 0, 2'b00, 0, 0);
        pulse(2'b01, 6, 0, 2'b01, 7, 0);
        chk("R8 both commits same cycle", own_io, 8'h02);
        chk("R8 io head", io_buf[2:0], 1);
        chk("R8 io len", io_len[9:0], 6);
        chk("R8 pk head", pk_buf[2:0], 2);
        chk("R8 no err", err, 0);
        do_reset(4'b0011);
        pulse(2'b01, 9, 0, 2'b01, 4, 0);
        chk("R8 io judged on old state", own_io, 8'h01);
        chk("R8 io commit on empty errs", err, 1);
        chk("R8 pk count kept", io_len[9:0], 9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_depth1_isolation();
        t_cfg_after_reset();
        t_oversize();
        t_simultaneous();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule